// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Interrupt Detection

This block is a general-purpose I/O port of eight pins reached over a simple byte-wide register bus with an address, a write strobe, write data and read data. Software controls each pin's direction and output level. The data and direction registers are reached through address windows whose address bits act as a per-pin mask. A single store can therefore change one pin, or any subset of pins, without reading the register first and writing it back.

Every pin can raise an interrupt. The options are a high level, a low level, a rising edge, a falling edge or either edge. Edge events latch in a raw status register until software clears them with a write-one-to-clear access. Level events follow the synchronized pin directly. A masked status view ANDs the raw status with an enable register, and a single interrupt line is the OR of that view. A separate select register picks which pins are handed to an alternate function, and its value is driven out of the block.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, `pin_oe`, `pin_out` and `alt_sel` are zero, and `irq` is low.
- R2: A write to the data window (address bits [11:10] = 00) changes only the output bits of pins whose bit in address [9:2] is 1. Pin n is selected by offset 4<<n, and offset 0x3FC selects all eight pins.
- R3: A read of the data or direction window returns zero for unmasked pins. In the data window, a masked output pin reads back its output register and a masked input pin reads back its synchronized input.
- R4: The direction window (address bits [11:10] = 10, so 0x800 plus the mask offset) holds one bit per pin, with 1 for output and 0 for input. `pin_oe` equals the direction register and `pin_out` equals the output register.
- R5: With sense bit = 1 (register 0x404), raw status (0x414) equals the synchronized input when the event bit (0x40C) is 1, and its inverse when the event bit is 0. It is not latched.
- R6: With sense bit = 0 and the both-edges bit (0x408) = 0, a rising edge sets the pin's raw status when the event bit is 1, and a falling edge sets it when the event bit is 0. The opposite edge does not set it, and the status stays set after the input returns.
- R7: With sense bit = 0 and the both-edges bit = 1, either transition sets the raw status, whatever the event bit holds.
- R8: Masked status (0x418) is raw status ANDed with the enable register (0x410), and `irq` is the OR of the masked status bits.
- R9: Writing 1 to a bit of the clear register (0x41C) clears that pin's latched edge status. An edge detected in the same cycle as the clear keeps the bit set. The register reads zero.
- R10: The alternate-function select register (0x420) reads back what was written, and it drives `alt_sel`.
- R11: Reads of unmapped offsets return zero, and writes to them have no effect. Writes to the raw and masked status registers have no effect.
- R12: An input change reaches the data-window read and the interrupt logic through a two-flop synchronizer. It is not visible after one clock edge and is visible after two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Output level register |
| pin_oe | output | 8 | Output enable per pin (1 = drive) |
| alt_sel | output | 8 | Alternate-function select per pin |
| irq | output | 1 | Combined interrupt |

## Verification
Some properties are checked on every cycle. A window write leaves the unmasked output and direction bits unchanged, an unmapped read returns zero, and the synchronizer output equals the input from two edges before. A latched edge bit only rises after the synchronized input changed, and it stays set until a clear arrives without a competing edge. The interrupt line is never high with all enables off. The bench scenarios show the rest: the exact sense and polarity choices per pin, readback of the output register against the input, the same-cycle clear race, and the one-edge versus two-edge visibility of an input change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_SENSE  = 12'h404;
    localparam logic [ADDR_W-1:0] OFS_BOTH   = 12'h408;
    localparam logic [ADDR_W-1:0] OFS_EVENT  = 12'h40C;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h410;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h418;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h41C;
    localparam logic [ADDR_W-1:0] OFS_ALT    = 12'h420;

    localparam logic [1:0] WIN_DATA = 2'b00;
    localparam logic [1:0] WIN_DIR  = 2'b10;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_DATA,
        RG_DIR,
        RG_SENSE,
        RG_BOTH,
        RG_EVENT,
        RG_ENABLE,
        RG_RAW,
        RG_MASKED,
        RG_CLEAR,
        RG_ALT
    } reg_sel_e;

    // Per-pin interrupt configuration
    typedef struct packed {
        logic level;      // 1: level sensing, 0: edge sensing
        logic any_edge;   // edge mode: trigger on both transitions
        logic active_hi;  // high level / rising edge when 1
    } pin_mode_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1 -: 2] == WIN_DATA) return RG_DATA;
        if (a[ADDR_W-1 -: 2] == WIN_DIR)  return RG_DIR;
        case (a)
            OFS_SENSE:  return RG_SENSE;
            OFS_BOTH:   return RG_BOTH;
            OFS_EVENT:  return RG_EVENT;
            OFS_ENABLE: return RG_ENABLE;
            OFS_RAW:    return RG_RAW;
            OFS_MASKED: return RG_MASKED;
            OFS_CLEAR:  return RG_CLEAR;
            OFS_ALT:    return RG_ALT;
            default:    return RG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [1:0]   age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
            age_q    <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
            if (age_q != 2'd2) age_q <= age_q + 2'd1;
        end
    end

    assign q = stage2_q;

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |-> (q == $past(d, 2)));  // R12

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_port_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPIN-1:0]       cur,
    input  pin_mode_t [NPIN-1:0]  mode,
    input  logic [NPIN-1:0]       clr,
    output logic [NPIN-1:0]       raw
);
    logic [NPIN-1:0] prev_q;
    logic [NPIN-1:0] stat_q;
    logic [NPIN-1:0] stat_d;
    logic [NPIN-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= cur;
            stat_q <= stat_d;
        end
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic rise;
        logic fall;
        logic lvl;

        always_comb begin
            rise   = cur[i] & ~prev_q[i];
            fall   = ~cur[i] & prev_q[i];
            hit[i] = 1'b0;
            if (!mode[i].level) begin
                if (mode[i].any_edge)       hit[i] = rise | fall;
                else if (mode[i].active_hi) hit[i] = rise;
                else                        hit[i] = fall;
            end
            lvl       = mode[i].active_hi ? cur[i] : ~cur[i];
            stat_d[i] = mode[i].level ? 1'b0 : ((stat_q[i] & ~clr[i]) | hit[i]);
            raw[i]    = mode[i].level ? lvl : stat_q[i];
        end

        AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
            $rose(stat_q[i]) |-> $past(cur[i] != prev_q[i]));  // R6

        AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (stat_q[i] && !clr[i] && !mode[i].level) |=> stat_q[i]);  // R9

        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !hit[i]) |=> !stat_q[i]);  // R9
    end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [NPIN-1:0]       bus_wdata,
    output logic [NPIN-1:0]       bus_rdata,
    input  logic [NPIN-1:0]       sync_in,
    input  logic [NPIN-1:0]       raw,
    output logic [NPIN-1:0]       out_q,
    output logic [NPIN-1:0]       dir_q,
    output logic [NPIN-1:0]       en_q,
    output logic [NPIN-1:0]       alt_q,
    output pin_mode_t [NPIN-1:0]  mode,
    output logic [NPIN-1:0]       clr
);
    localparam int MASK_LO = 2;
    localparam int MASK_HI = MASK_LO + NPIN - 1;

    reg_sel_e        sel;
    logic [NPIN-1:0] pmask;
    logic [NPIN-1:0] sense_q;
    logic [NPIN-1:0] both_q;
    logic [NPIN-1:0] event_q;
    logic [NPIN-1:0] data_view;

    assign sel   = decode_addr(bus_addr);
    assign pmask = bus_addr[MASK_HI:MASK_LO];
    assign clr   = (bus_we && sel == RG_CLEAR) ? bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            dir_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            event_q <= '0;
            en_q    <= '0;
            alt_q   <= '0;
        end else if (bus_we) begin
            case (sel)
                RG_DATA:   out_q   <= (out_q & ~pmask) | (bus_wdata & pmask);
                RG_DIR:    dir_q   <= (dir_q & ~pmask) | (bus_wdata & pmask);
                RG_SENSE:  sense_q <= bus_wdata;
                RG_BOTH:   both_q  <= bus_wdata;
                RG_EVENT:  event_q <= bus_wdata;
                RG_ENABLE: en_q    <= bus_wdata;
                RG_ALT:    alt_q   <= bus_wdata;
                default:   ;
            endcase
        end
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_mode
        assign mode[i] = '{level: sense_q[i], any_edge: both_q[i], active_hi: event_q[i]};
    end

    assign data_view = (dir_q & out_q) | (~dir_q & sync_in);

    always_comb begin
        case (sel)
            RG_DATA:   bus_rdata = data_view & pmask;
            RG_DIR:    bus_rdata = dir_q & pmask;
            RG_SENSE:  bus_rdata = sense_q;
            RG_BOTH:   bus_rdata = both_q;
            RG_EVENT:  bus_rdata = event_q;
            RG_ENABLE: bus_rdata = en_q;
            RG_RAW:    bus_rdata = raw;
            RG_MASKED: bus_rdata = raw & en_q;
            RG_ALT:    bus_rdata = alt_q;
            default:   bus_rdata = '0;
        endcase
    end

    AST_DATA_MASKED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == RG_DATA) |=> (((out_q ^ $past(out_q)) & ~$past(pmask)) == '0));  // R2

    AST_DIR_MASKED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == RG_DIR) |=> (((dir_q ^ $past(dir_q)) & ~$past(pmask)) == '0));  // R4

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
        (sel == RG_NONE) |-> (bus_rdata == '0));  // R11

    AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (rst)
        (clr != '0) |-> (bus_we && bus_addr == OFS_CLEAR));  // R9

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN-1:0]   alt_sel,
    output logic              irq
);
    logic [NPIN-1:0]      sync_in;
    logic [NPIN-1:0]      raw;
    logic [NPIN-1:0]      en_q;
    logic [NPIN-1:0]      clr;
    pin_mode_t [NPIN-1:0] mode;

    gpio_sync2 #(.W(NPIN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (sync_in)
    );

    gpio_regs #(.NPIN(NPIN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sync_in   (sync_in),
        .raw       (raw),
        .out_q     (pin_out),
        .dir_q     (pin_oe),
        .en_q      (en_q),
        .alt_q     (alt_sel),
        .mode      (mode),
        .clr       (clr)
    );

    gpio_irq_detect #(.NPIN(NPIN)) u_detect (
        .clk  (clk),
        .rst  (rst),
        .cur  (sync_in),
        .mode (mode),
        .clr  (clr),
        .raw  (raw)
    );

    assign irq = |(raw & en_q);

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (en_q != '0));  // R8

endmodule

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic [7:0]  alt_sel;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_port u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .alt_sel   (alt_sel),
        .irq       (irq)
    );

    typedef struct packed {
        logic [11:0] wa;
        logic        we;
        logic [7:0]  wd;
        logic [11:0] ra;
        logic [7:0]  exp;
        logic [7:0]  req;
    } step_t;

    localparam int NSTEP = 11;
    localparam step_t STEPS [NSTEP] = '{
        '{12'hBFC, 1'b1, 8'h0F, 12'hBFC, 8'h0F, 8'd4},   // R4 dir pins 0-3 out
        '{12'h000, 1'b0, 8'h00, 12'h810, 8'h04, 8'd3},   // R3 single-pin dir read
        '{12'h3FC, 1'b1, 8'hA5, 12'h3FC, 8'h05, 8'd3},   // R3 outputs read reg, inputs read pins
        '{12'h008, 1'b1, 8'hFF, 12'h03C, 8'h07, 8'd2},   // R2 set pin 1 only
        '{12'h008, 1'b1, 8'h00, 12'h03C, 8'h05, 8'd2},   // R2 clear pin 1 only
        '{12'h420, 1'b1, 8'h3C, 12'h420, 8'h3C, 8'd10},  // R10
        '{12'h414, 1'b1, 8'hFF, 12'h414, 8'h00, 8'd11},  // R11 raw read-only
        '{12'h440, 1'b1, 8'hFF, 12'h440, 8'h00, 8'd11},  // R11 unmapped
        '{12'h000, 1'b0, 8'h00, 12'hC10, 8'h00, 8'd11},  // R11 above windows
        '{12'h410, 1'b1, 8'h81, 12'h410, 8'h81, 8'd8},   // R8 enable readback
        '{12'h41C, 1'b1, 8'hFF, 12'h41C, 8'h00, 8'd9}    // R9 clear reads zero
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
        v = bus_rdata;
    endtask

    task automatic pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(8ns * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pin_out", pin_out, 8'h00);
        check("R1 alt_sel", alt_sel, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        rd(12'h404, v); check("R1 sense", v, 8'h00);
        rd(12'h410, v); check("R1 enable", v, 8'h00);
        rd(12'h414, v); check("R1 raw", v, 8'h00);

        for (int k = 0; k < NSTEP; k++) begin
            if (STEPS[k].we) wr(STEPS[k].wa, STEPS[k].wd);
            rd(STEPS[k].ra, v);
            check($sformatf("R%0d step %0d", STEPS[k].req, k), v, STEPS[k].exp);
        end
        check("R4 pin_oe", pin_oe, 8'h0F);
        check("R2 pin_out", pin_out, 8'hA5);
        check("R10 alt_sel", alt_sel, 8'h3C);

        // all pins back to inputs
        wr(12'hBFC, 8'h00);
        check("R4 pin_oe inputs", pin_oe, 8'h00);

        // R12 synchronizer latency on pin 4
        @(negedge clk);
        pin_in = 8'h10;
        @(posedge clk);
        rd(12'h040, v); check("R12 one edge", v, 8'h00);
        @(posedge clk);
        #1;
        bus_addr = 12'h040;
        #1;
        check("R12 two edges", bus_rdata, 8'h10);

        // R5 level sensing on pin 4
        wr(12'h404, 8'h10);
        wr(12'h40C, 8'h10);
        rd(12'h414, v); check("R5 high level", v, 8'h10);
        pins(8'h00);
        rd(12'h414, v); check("R5 not latched", v, 8'h00);
        wr(12'h40C, 8'h00);
        rd(12'h414, v); check("R5 low level", v, 8'h10);
        rd(12'h418, v); check("R8 masked off", v, 8'h00);
        check("R8 irq off", {7'd0, irq}, 8'h00);
        wr(12'h410, 8'h10);
        rd(12'h418, v); check("R8 masked on", v, 8'h10);
        check("R8 irq on", {7'd0, irq}, 8'h01);
        pins(8'h10);
        check("R8 irq drops", {7'd0, irq}, 8'h00);

        // back to edge mode, clean slate
        wr(12'h404, 8'h00);
        wr(12'h41C, 8'hFF);
        rd(12'h414, v); check("R9 clean", v, 8'h00);

        // R6 rising edge on pin 0
        wr(12'h40C, 8'h01);
        pins(8'h11);
        rd(12'h414, v); check("R6 rise set", v, 8'h01);
        check("R8 irq masked edge", {7'd0, irq}, 8'h00);
        pins(8'h10);
        rd(12'h414, v); check("R6 latched", v, 8'h01);
        wr(12'h41C, 8'h01);
        rd(12'h414, v); check("R9 cleared", v, 8'h00);
        pins(8'h11);
        wr(12'h41C, 8'h01);
        pins(8'h10);
        rd(12'h414, v); check("R6 fall ignored", v, 8'h00);

        // R6 falling edge on pin 1
        pins(8'h12);
        rd(12'h414, v); check("R6 rise ignored", v, 8'h00);
        pins(8'h10);
        rd(12'h414, v); check("R6 fall set", v, 8'h02);
        wr(12'h41C, 8'h02);

        // R7 both edges on pin 2, event bit = 1
        wr(12'h40C, 8'h05);
        wr(12'h408, 8'h04);
        pins(8'h14);
        rd(12'h414, v); check("R7 rise", v, 8'h04);
        wr(12'h41C, 8'h04);
        rd(12'h414, v); check("R7 cleared", v, 8'h00);
        pins(8'h10);
        rd(12'h414, v); check("R7 fall", v, 8'h04);

        // R9 edge in same cycle as clear wins
        @(negedge clk);
        pin_in = 8'h14;
        @(posedge clk);
        @(posedge clk);
        wr(12'h41C, 8'h04);
        rd(12'h414, v); check("R9 edge wins", v, 8'h04);
        wr(12'h41C, 8'h04);
        rd(12'h414, v); check("R9 clear without edge", v, 8'h00);

        finish_run();
    end

endmodule